// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the timing skeleton of a parallel RGB video output: horizontal sync, vertical sync, a data-enable strobe and the column and row of the pixel currently being shown. It carries no pixel data. A downstream pixel source uses the coordinates to fetch data, and the panel uses the sync and enable strobes to frame it. Each line is built from four segments in a fixed order: sync, back porch, active, front porch. Frames use the same order, counted in lines. Software programs every segment length as its true count minus one.

Software controls the block over a small register bus with separate write and read strobes. The bus provides a run request, a choice between stopping at once or at the end of the current frame, a busy flag to poll, a self-clearing soft reset, sync polarity selection, and two interrupt sources (frame start and frame done). Each source has a write-one-to-clear pending bit. A master enable and a source select decide which pending bit drives the interrupt line. Timing values are shadowed and take effect only when a new frame begins.

Register map (3-bit word address, 32-bit data):

- 0 control: [0] run, [1] stop at frame end, [2] soft reset, [3] busy (read only), [4] horizontal sync active high, [5] vertical sync active high.
- 1: active width minus one in [11:0].
- 2: active height minus one in [11:0].
- 3 horizontal segments: sync [7:0], back porch [15:8], front porch [23:16], each minus one.
- 4: the same layout for the vertical segments, in lines.
- 5 interrupt config: [0] master enable, [1] select (0 = frame start, 1 = frame done).
- 6 interrupt status: [0] frame-start pending, [1] frame-done pending.

Top module: `disp_tgen`

## Requirements
- R1: After reset, every register reads zero. The outputs are idle: both syncs high, enable low, coordinates zero, interrupt low.
- R2: While running, each line has hsync_o at its active level for (sync+1) pixels, then (back+1) pixels, then (width+1) active pixels, then (front+1) pixels, and the next line follows directly. When stopped, hsync_o sits at its inactive level.
- R3: Lines are counted into frames in the same order: (vsync+1) lines of vsync_o active, then (vback+1), (height+1) and (vfront+1) lines.
- R4: de_o is high only where both the horizontal and the vertical counts are in their active segments. There, px_x_o and px_y_o give the offsets from the start of the active segments. Elsewhere the coordinates are zero.
- R5: Writes to the size and segment registers do not change the frame in progress. They apply from the next frame start.
- R6: Setting run while stopped starts a frame. Its first pixel, at count (0,0), appears in the cycle after the second rising edge following the write. With stop-at-frame-end clear, clearing run stops the output at the next edge.
- R7: With stop-at-frame-end set, clearing run lets the current frame finish. The busy bit reads 1 until the output has stopped.
- R8: Writing 1 to control bit 2 resets all registers and the output. The bit reads 1 for one cycle and then clears itself.
- R9: Frame-start pending is set when a frame's first pixel is shown. Frame-done pending is set after its last pixel. Writing 1 to a status bit clears it, and a new event in the same cycle keeps it set.
- R10: irq_o equals the master enable ANDed with the pending bit chosen by the select.
- R11: Control bits 4 and 5 switch the respective sync to active high. Their reset value gives active-low syncs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears after one edge |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| px_x_o | output | 12 | Active column |
| px_y_o | output | 12 | Active row |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 12-bit sizes, 8-bit segment fields and a 32-bit bus. It programs small segment values, with one-pixel front porches and one-line sync, so that a frame lasts about a hundred cycles. This puts several frame wraps, a mid-frame timing change, a deferred and an immediate stop, and a soft reset within a short run. The reference model recomputes every output on every cycle from the programmed values and from the shadow it takes at each frame start.

// File: rtl/disp_tgen_pkg.sv
// Package: register addresses and bit positions shared by the timing
// generator and its register file. Assumes a 3-bit word address.
package disp_tgen_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 3'd0,
        RA_HSIZE   = 3'd1,
        RA_VSIZE   = 3'd2,
        RA_HSEG    = 3'd3,
        RA_VSEG    = 3'd4,
        RA_IRQCFG  = 3'd5,
        RA_IRQSTAT = 3'd6
    } reg_addr_e;

    localparam int CB_RUN   = 0;
    localparam int CB_DEFER = 1;
    localparam int CB_SWRST = 2;
    localparam int CB_BUSY  = 3;
    localparam int CB_HPOL  = 4;
    localparam int CB_VPOL  = 5;

    localparam int IB_EN  = 0;
    localparam int IB_SEL = 1;

    localparam int SB_START = 0;
    localparam int SB_DONE  = 1;
endpackage

// File: rtl/disp_tgen_axis.sv
// Module: one counting axis (pixels in a line, or lines in a frame).
// Walks through sync, back porch, active and front porch segments whose
// lengths are given minus one, and wraps after the last count.
// Assumes the length inputs stay stable while counting (they are shadowed).
module disp_tgen_axis #(
    parameter int HW = 12,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic [PW-1:0] sync_m1_i,
    input  logic [PW-1:0] bp_m1_i,
    input  logic [HW-1:0] act_m1_i,
    input  logic [PW-1:0] fp_m1_i,
    output logic          last_o,
    output logic          sync_o,
    output logic          act_o,
    output logic [HW-1:0] pos_o
);
    localparam int CW = HW + 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] end_sync, end_bp, end_act, last_cnt;

    // Segment boundaries derived from the minus-one lengths
    always_comb begin
        end_sync = CW'(sync_m1_i) + CW'(1);
        end_bp   = end_sync + CW'(bp_m1_i) + CW'(1);
        end_act  = end_bp + CW'(act_m1_i) + CW'(1);
        last_cnt = end_act + CW'(fp_m1_i);
    end

    // Position counter: cleared when idle, wraps after the last count
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            cnt_q <= '0;
        else if (step_i)
            cnt_q <= last_o ? '0 : cnt_q + CW'(1);
    end

    assign last_o = (cnt_q == last_cnt);
    assign sync_o = (cnt_q < end_sync);
    assign act_o  = (cnt_q >= end_bp) && (cnt_q < end_act);
    assign pos_o  = HW'(cnt_q - end_bp);
endmodule

// File: rtl/disp_tgen_regs.sv
// Module: register file of the timing generator. Holds the control bits,
// the programmed sizes and segment lengths, the interrupt configuration and
// the write-one-to-clear pending bits, and forms the interrupt line.
// A soft reset clears everything here one edge after it is written.
module disp_tgen_regs
    import disp_tgen_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 12,
    parameter int PW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic              busy_i,
    input  logic              frm_start_i,
    input  logic              frm_done_i,
    output logic              run_o,
    output logic              defer_o,
    output logic              hpol_o,
    output logic              vpol_o,
    output logic              swrst_o,
    output logic [HW-1:0]     h_act_o,
    output logic [HW-1:0]     v_act_o,
    output logic [PW-1:0]     h_sync_o,
    output logic [PW-1:0]     h_bp_o,
    output logic [PW-1:0]     h_fp_o,
    output logic [PW-1:0]     v_sync_o,
    output logic [PW-1:0]     v_bp_o,
    output logic [PW-1:0]     v_fp_o,
    output logic              irq_o
);
    logic          clr;
    logic          irq_en, irq_sel, start_pend, done_pend, stat_wr;
    logic [DW-1:0] rd_mux;

    assign clr     = !rst_n || swrst_o;
    assign stat_wr = wr_i && (addr_i == RA_IRQSTAT);

    // Configuration registers written from the bus
    always_ff @(posedge clk) begin
        if (clr) begin
            {run_o, defer_o, hpol_o, vpol_o, swrst_o} <= '0;
            {h_act_o, v_act_o} <= '0;
            {h_sync_o, h_bp_o, h_fp_o} <= '0;
            {v_sync_o, v_bp_o, v_fp_o} <= '0;
            {irq_en, irq_sel} <= '0;
        end else if (wr_i) begin
            case (addr_i)
                RA_CTRL: begin
                    run_o   <= wdata_i[CB_RUN];
                    defer_o <= wdata_i[CB_DEFER];
                    swrst_o <= wdata_i[CB_SWRST];
                    hpol_o  <= wdata_i[CB_HPOL];
                    vpol_o  <= wdata_i[CB_VPOL];
                end
                RA_HSIZE: h_act_o <= wdata_i[HW-1:0];
                RA_VSIZE: v_act_o <= wdata_i[HW-1:0];
                RA_HSEG: begin
                    h_sync_o <= wdata_i[PW-1:0];
                    h_bp_o   <= wdata_i[2*PW-1:PW];
                    h_fp_o   <= wdata_i[3*PW-1:2*PW];
                end
                RA_VSEG: begin
                    v_sync_o <= wdata_i[PW-1:0];
                    v_bp_o   <= wdata_i[2*PW-1:PW];
                    v_fp_o   <= wdata_i[3*PW-1:2*PW];
                end
                RA_IRQCFG: begin
                    irq_en  <= wdata_i[IB_EN];
                    irq_sel <= wdata_i[IB_SEL];
                end
                default: ;
            endcase
        end
    end

    // Pending bits: write one clears, a same-cycle event keeps them set
    always_ff @(posedge clk) begin
        if (clr) begin
            start_pend <= 1'b0;
            done_pend  <= 1'b0;
        end else begin
            start_pend <= (start_pend && !(stat_wr && wdata_i[SB_START])) || frm_start_i;
            done_pend  <= (done_pend && !(stat_wr && wdata_i[SB_DONE])) || frm_done_i;
        end
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            RA_CTRL: begin
                rd_mux[CB_RUN]   = run_o;
                rd_mux[CB_DEFER] = defer_o;
                rd_mux[CB_SWRST] = swrst_o;
                rd_mux[CB_BUSY]  = busy_i;
                rd_mux[CB_HPOL]  = hpol_o;
                rd_mux[CB_VPOL]  = vpol_o;
            end
            RA_HSIZE: rd_mux[HW-1:0] = h_act_o;
            RA_VSIZE: rd_mux[HW-1:0] = v_act_o;
            RA_HSEG:  rd_mux[3*PW-1:0] = {h_fp_o, h_bp_o, h_sync_o};
            RA_VSEG:  rd_mux[3*PW-1:0] = {v_fp_o, v_bp_o, v_sync_o};
            RA_IRQCFG: begin
                rd_mux[IB_EN]  = irq_en;
                rd_mux[IB_SEL] = irq_sel;
            end
            RA_IRQSTAT: begin
                rd_mux[SB_START] = start_pend;
                rd_mux[SB_DONE]  = done_pend;
            end
            default: ;
        endcase
    end

    // Registered read data, captured on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rd_mux;
    end

    assign irq_o = irq_en && (irq_sel ? done_pend : start_pend);
endmodule

// File: rtl/disp_tgen.sv
// Module: display timing generator top. Sequences run/stop at frame
// granularity, shadows the timing registers at every frame start, drives
// two counting axes and forms sync, enable and coordinate outputs.
// Assumes a single pixel clock and a synchronous active-low reset.
module disp_tgen
    import disp_tgen_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 12,
    parameter int PW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [HW-1:0]     px_x_o,
    output logic [HW-1:0]     px_y_o,
    output logic              irq_o
);
    localparam int NAX = 2;

    logic          run, defer, hpol, vpol, swrst, running, eof, core_rst_n;
    logic          start_now, stop_now, frm_start, frm_done;
    logic [HW-1:0] r_act  [NAX];
    logic [PW-1:0] r_sync [NAX];
    logic [PW-1:0] r_bp   [NAX];
    logic [PW-1:0] r_fp   [NAX];
    logic [HW-1:0] s_act  [NAX];
    logic [PW-1:0] s_sync [NAX];
    logic [PW-1:0] s_bp   [NAX];
    logic [PW-1:0] s_fp   [NAX];
    logic [NAX-1:0] ax_last, ax_sync, ax_act, ax_step;
    logic [HW-1:0] ax_pos [NAX];

    disp_tgen_regs #(.DW(DW), .HW(HW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd),
        .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .busy_i(running), .frm_start_i(frm_start), .frm_done_i(frm_done),
        .run_o(run), .defer_o(defer), .hpol_o(hpol), .vpol_o(vpol),
        .swrst_o(swrst),
        .h_act_o(r_act[0]), .v_act_o(r_act[1]),
        .h_sync_o(r_sync[0]), .h_bp_o(r_bp[0]), .h_fp_o(r_fp[0]),
        .v_sync_o(r_sync[1]), .v_bp_o(r_bp[1]), .v_fp_o(r_fp[1]),
        .irq_o(irq_o)
    );

    assign core_rst_n = rst_n && !swrst;
    assign eof        = running && ax_last[0] && ax_last[1];
    assign start_now  = !running && run;
    assign stop_now   = running && !run && !defer;
    assign frm_start  = start_now || (eof && run);
    assign frm_done   = eof && !stop_now;

    // Run state: start at a frame boundary, stop at once or at frame end
    always_ff @(posedge clk) begin
        if (!core_rst_n)
            running <= 1'b0;
        else if (start_now)
            running <= 1'b1;
        else if (stop_now || (eof && !run))
            running <= 1'b0;
    end

    // Axis 0 steps every pixel, axis 1 steps at each line end
    assign ax_step[0] = running;
    assign ax_step[1] = running && ax_last[0];

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        // Shadow copy of this axis' timing, loaded at each frame start
        always_ff @(posedge clk) begin
            if (!core_rst_n) begin
                s_act[a]  <= '0;
                s_sync[a] <= '0;
                s_bp[a]   <= '0;
                s_fp[a]   <= '0;
            end else if (frm_start) begin
                s_act[a]  <= r_act[a];
                s_sync[a] <= r_sync[a];
                s_bp[a]   <= r_bp[a];
                s_fp[a]   <= r_fp[a];
            end
        end

        disp_tgen_axis #(.HW(HW), .PW(PW)) u_axis (
            .clk(clk), .rst_n(core_rst_n), .clear_i(!running),
            .step_i(ax_step[a]),
            .sync_m1_i(s_sync[a]), .bp_m1_i(s_bp[a]),
            .act_m1_i(s_act[a]), .fp_m1_i(s_fp[a]),
            .last_o(ax_last[a]), .sync_o(ax_sync[a]),
            .act_o(ax_act[a]), .pos_o(ax_pos[a])
        );
    end

    assign de_o    = running && ax_act[0] && ax_act[1];
    assign hsync_o = !((running && ax_sync[0]) ^ hpol);
    assign vsync_o = !((running && ax_sync[1]) ^ vpol);
    assign px_x_o  = de_o ? ax_pos[0] : '0;
    assign px_y_o  = de_o ? ax_pos[1] : '0;
endmodule

// File: rtl/disp_tgen_chk.sv
// Module: assertion checker for the timing generator, bound to the top.
// Assumes the signals it is connected to exist in the top scope.
module disp_tgen_chk (
    input logic clk,
    input logic rst_n,
    input logic running,
    input logic eof,
    input logic swrst,
    input logic defer,
    input logic hpol,
    input logic hsync_o,
    input logic de_o
);
    // R4: the data enable is never high while the output is stopped
    a_r4_de_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> running);

    // R2: a stopped output holds hsync at its inactive level
    a_r2_idle_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (hsync_o == !hpol));

    // R6: a start always lands on the first pixel of a line's sync segment
    a_r6_start_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (hsync_o == hpol));

    // R7: with stop-at-frame-end, running only falls after the last pixel
    a_r7_stop_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(running) && $past(defer) && !$past(swrst)) |-> $past(eof));

    // R8: the soft reset bit clears itself after one cycle
    a_r8_swrst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> !swrst);
endmodule

bind disp_tgen disp_tgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .eof(eof),
    .swrst(swrst), .defer(defer), .hpol(hpol),
    .hsync_o(hsync_o), .de_o(de_o)
);

// File: tb/disp_tgen_tb.sv
// Bench: behavioural reference model updated on each rising edge and
// compared against every output on each falling edge; register reads are
// checked against the model's view of the registers.
module disp_tgen_tb;
    localparam int DW = 32;
    localparam int HW = 12;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          hsync_o, vsync_o, de_o, irq_o;
    logic [HW-1:0] px_x_o, px_y_o;

    always #10 clk = ~clk;

    disp_tgen #(.DW(DW), .HW(HW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .px_x_o(px_x_o), .px_y_o(px_y_o), .irq_o(irq_o)
    );

    int vectors = 0, fails = 0;
    bit cmp_on = 1'b0, finished = 1'b0;
    string phase = "R1";

    // Model state: programmed values, shadows, position and pending bits
    int m_run = 0, m_defer = 0, m_hpol = 0, m_vpol = 0, m_swrst = 0;
    int m_ien = 0, m_isel = 0, m_sp = 0, m_dp = 0, m_running = 0, m_h = 0, m_v = 0;
    int p_hact = 0, p_vact = 0, p_hs = 0, p_hb = 0, p_hf = 0, p_vs = 0, p_vb = 0, p_vf = 0;
    int s_hact = 0, s_vact = 0, s_hs = 0, s_hb = 0, s_hf = 0, s_vs = 0, s_vb = 0, s_vf = 0;

    task automatic model_clear();
        {m_run, m_defer, m_hpol, m_vpol, m_swrst} = '0;
        {m_ien, m_isel, m_sp, m_dp, m_running, m_h, m_v} = '0;
        {p_hact, p_vact, p_hs, p_hb, p_hf, p_vs, p_vb, p_vf} = '0;
        {s_hact, s_vact, s_hs, s_hb, s_hf, s_vs, s_vb, s_vf} = '0;
    endtask

    // Reference model: one step per rising edge using pre-edge values
    always @(posedge clk) begin
        if (!rst_n || m_swrst != 0) begin
            model_clear();
        end else begin
            int htot, vtot, fs, fd, wst;
            bit eof;
            htot = s_hs + s_hb + s_hact + s_hf + 4;
            vtot = s_vs + s_vb + s_vact + s_vf + 4;
            eof = (m_running != 0) && m_h == htot - 1 && m_v == vtot - 1;
            fs = 0; fd = 0;
            if (m_running == 0) begin
                m_h = 0; m_v = 0;
                if (m_run != 0) begin m_running = 1; fs = 1; end
            end else if (m_run == 0 && m_defer == 0) begin
                m_running = 0; m_h = 0; m_v = 0;
            end else if (eof) begin
                fd = 1; m_h = 0; m_v = 0;
                if (m_run != 0) fs = 1; else m_running = 0;
            end else if (m_h == htot - 1) begin
                m_h = 0; m_v++;
            end else begin
                m_h++;
            end
            if (fs != 0) begin
                s_hact = p_hact; s_vact = p_vact;
                s_hs = p_hs; s_hb = p_hb; s_hf = p_hf;
                s_vs = p_vs; s_vb = p_vb; s_vf = p_vf;
            end
            wst = (reg_wr && reg_addr == 3'd6) ? 1 : 0;
            m_sp = ((m_sp != 0 && !(wst != 0 && reg_wdata[0])) || fs != 0) ? 1 : 0;
            m_dp = ((m_dp != 0 && !(wst != 0 && reg_wdata[1])) || fd != 0) ? 1 : 0;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin
                        m_run = reg_wdata[0]; m_defer = reg_wdata[1];
                        m_swrst = reg_wdata[2]; m_hpol = reg_wdata[4];
                        m_vpol = reg_wdata[5];
                    end
                    3'd1: p_hact = reg_wdata[11:0];
                    3'd2: p_vact = reg_wdata[11:0];
                    3'd3: begin p_hs = reg_wdata[7:0]; p_hb = reg_wdata[15:8]; p_hf = reg_wdata[23:16]; end
                    3'd4: begin p_vs = reg_wdata[7:0]; p_vb = reg_wdata[15:8]; p_vf = reg_wdata[23:16]; end
                    3'd5: begin m_ien = reg_wdata[0]; m_isel = reg_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [DW-1:0] model_reg(input int a);
        logic [DW-1:0] v;
        v = '0;
        case (a)
            0: v = DW'(m_run | (m_defer << 1) | (m_swrst << 2) | (m_running << 3)
                       | (m_hpol << 4) | (m_vpol << 5));
            1: v = DW'(p_hact);
            2: v = DW'(p_vact);
            3: v = DW'(p_hs | (p_hb << 8) | (p_hf << 16));
            4: v = DW'(p_vs | (p_vb << 8) | (p_vf << 16));
            5: v = DW'(m_ien | (m_isel << 1));
            6: v = DW'(m_sp | (m_dp << 1));
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic report(input string tag, input longint act, input longint exp);
        fails++;
        $display("FAIL %s [phase %s] got %0h expected %0h at %0t", tag, phase, act, exp, $time);
    endtask

    // Per-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            int hs, hb, vs, vb, ex, ey;
            bit hact, vact, e_de, e_hs, e_vs, e_irq;
            hs = s_hs + 1; hb = s_hb + 1; vs = s_vs + 1; vb = s_vb + 1;
            hact = m_h >= hs + hb && m_h < hs + hb + s_hact + 1;
            vact = m_v >= vs + vb && m_v < vs + vb + s_vact + 1;
            e_de = (m_running != 0) && hact && vact;
            e_hs = ((m_running != 0) && m_h < hs) ? (m_hpol != 0) : (m_hpol == 0);
            e_vs = ((m_running != 0) && m_v < vs) ? (m_vpol != 0) : (m_vpol == 0);
            ex = e_de ? m_h - hs - hb : 0;
            ey = e_de ? m_v - vs - vb : 0;
            e_irq = (m_ien != 0) && ((m_isel != 0) ? (m_dp != 0) : (m_sp != 0));
            vectors++;
            if (hsync_o !== e_hs) report("R2/R11 hsync_o", hsync_o, e_hs);
            if (vsync_o !== e_vs) report("R3/R11 vsync_o", vsync_o, e_vs);
            if (de_o !== e_de) report("R4 de_o", de_o, e_de);
            if (px_x_o !== HW'(ex)) report("R4 px_x_o", px_x_o, ex);
            if (px_y_o !== HW'(ey)) report("R4 px_y_o", px_y_o, ey);
            if (irq_o !== e_irq) report("R10/R9 irq_o", irq_o, e_irq);
        end
    end

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Read one register; the expected value is the model's pre-edge view
    task automatic do_read(input int a, input string tag);
        logic [DW-1:0] exp;
        reg_rd = 1'b1; reg_addr = 3'(a);
        exp = model_reg(a);
        @(negedge clk);
        reg_rd = 1'b0;
        vectors++;
        if (reg_rdata !== exp) report(tag, reg_rdata, exp);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        phase = "R1";
        wait_cycles(4);
        @(negedge clk);
        do_read(0, "R1 control after reset");
        do_read(1, "R1 width after reset");
        do_read(6, "R1 status after reset");

        phase = "R2";
        do_write(1, 32'd5);
        do_write(3, 32'h0000_0201);
        do_write(2, 32'd3);
        do_write(4, 32'h0001_0100);
        do_write(5, 32'h1);
        do_write(0, 32'h3);
        phase = "R3";
        wait_cycles(250);

        phase = "R9";
        do_read(6, "R9 pending after frames");
        do_write(6, 32'h1);
        do_read(6, "R9 after write-one-to-clear");
        phase = "R10";
        do_write(5, 32'h3);
        wait_cycles(20);
        do_write(6, 32'h3);
        do_read(6, "R9 both cleared");

        phase = "R5";
        do_write(1, 32'd2);
        do_write(3, 32'h0);
        wait_cycles(250);

        phase = "R7";
        do_write(0, 32'h2);
        do_read(0, "R7 busy while finishing frame");
        wait_cycles(120);
        do_read(0, "R7 busy after frame end");

        phase = "R6";
        do_write(0, 32'h1);
        wait_cycles(30);
        do_write(0, 32'h0);
        wait_cycles(10);
        do_read(0, "R6 stopped at once");

        phase = "R11";
        do_write(0, 32'h31);
        wait_cycles(60);

        phase = "R8";
        do_write(0, 32'h35);
        do_read(0, "R8 reset bit visible");
        do_read(0, "R8 reset bit self-cleared");
        do_read(1, "R8 width back to default");
        do_read(5, "R8 irq config back to default");
        wait_cycles(10);

        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired in phase %s", phase);
            summary();
            $finish;
        end
    end
endmodule